// File: doc/BRIEF.md
# Dual-Bank Swappable Byte Buffer

This block keeps two equal byte-wide buffer banks and hands one to a host and the other to an internal DMA engine. The host side is an 8-bit strobe bus (active-low chip select, write strobe and output enable), sampled in the block's clock domain. The DMA side is a pair of byte streams with valid/ready handshakes. Each side only ever addresses the bank it currently owns, so a microcontroller can fill or drain one bank while the DMA engine streams the other.

The host never addresses bank cells directly. It goes through a small register file: a write-only transmit window and a read-only receive window that both work at a shared host pointer, two pointer registers, and a control register. A control write asks for the banks to trade owners. The trade is applied only while the DMA side is idle, and it rewinds both pointers to zero. The bank depth is 2^`PTR_W` bytes. The default of 10 keeps elaboration small, and `PTR_W` = 13 gives 8 KiB per bank.

Back-pressure rules on the DMA streams:
- The write stream accepts a byte on every cycle where `dma_wr_valid` and `dma_wr_ready` are both high.
- `dma_wr_ready` is low while the read stream is enabled.
- On the read stream, `dma_rd_valid`, once raised, stays high with unchanged data until `dma_rd_ready` takes the byte or `dma_rd_en` drops.
- After each accepted read byte there is one bubble cycle while the bank fetches the next address.

Top module: `dual_bank_buffer`

## Requirements
- R1: After reset:
  - bank 0 is host-owned;
  - both pointers are 0;
  - `host_rdata` is 0;
  - `dma_rd_valid` is 0;
  - `dma_wr_ready` is 1;
  - a read of the control register returns 0x00.
- R2: A host write to offset 0x04 (transmit window) stores the byte at the host pointer of the host-owned bank and then advances the pointer by one. A host read of offset 0x05 (receive window) returns the byte at the host pointer and then advances it by one.
- R3: Host pointer access:
  - writing offset 0x01 loads pointer bits [7:0];
  - writing offset 0x02 loads the pointer bits above bit 7;
  - reading either offset returns those bits, zero-extended;
  - writing the control register (offset 0x00) with bit 1 set clears the pointer;
  - the pointer wraps from 2^PTR_W-1 to 0.
- R4: A control write requests bit 0 as the host-owned bank index. If the DMA side is idle (`dma_wr_valid` low and `dma_rd_en` low), ownership changes at that clock edge. Otherwise the request stays pending and is applied on the first idle cycle. Control reads return bit 0 = current host bank and bit 1 = request pending.
- R5: Every ownership change sets both the host pointer and the DMA pointer to 0.
- R6: Each side reads and writes only its own bank. Bytes written by the DMA side become visible to the host only after a swap, and DMA writes never alter the host-owned bank.
- R7: DMA write stream:
  - `dma_wr_ready` is high exactly when `dma_rd_en` is low;
  - each accepted byte is stored at the DMA pointer;
  - the DMA pointer then advances by one.
- R8: DMA read stream:
  - with `dma_rd_en` high, `dma_rd_valid` rises with the byte at the DMA pointer;
  - valid and data hold while `dma_rd_ready` is low;
  - each accepted byte advances the DMA pointer by one.
- R9: Writes to the receive window and reads of the transmit window have no effect on storage or pointer. Reads of the transmit window or of unmapped offsets return 0x00.
- R10: An access happens only on the cycle a strobe is first seen low while `host_cs_n` is low. Strobes with chip select high do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_we_n | input | 1 | Host write strobe, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| host_addr | input | 8 | Host register offset |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Byte captured by the last host read |
| host_rdata_oe | output | 1 | High while the host data pins should be driven |
| dma_wr_valid | input | 1 | DMA write byte valid |
| dma_wr_data | input | 8 | DMA write byte |
| dma_wr_ready | output | 1 | DMA write byte accepted when high |
| dma_rd_en | input | 1 | Enables the DMA read stream |
| dma_rd_valid | output | 1 | DMA read byte valid |
| dma_rd_data | output | 8 | DMA read byte |
| dma_rd_ready | input | 1 | DMA consumer takes the byte |

## Verification
The assertions assume a well-behaved host: each strobe goes high for at least one clock between accesses, and address and data are held stable while a strobe is low. They also assume the DMA consumer keeps `dma_rd_en` high while it holds a read byte. The stimulus drives every host access as one strobe-low phase of two clocks followed by a high gap of two clocks, with all inputs changed only on falling edges. It lowers `dma_rd_en` only when no read byte is outstanding.

// File: rtl/dbb_pkg.sv
package dbb_pkg;
  typedef logic [7:0] byte_t;
  localparam byte_t OFS_CTRL  = 8'h00;
  localparam byte_t OFS_PTRL  = 8'h01;
  localparam byte_t OFS_PTRH  = 8'h02;
  localparam byte_t OFS_TXWIN = 8'h04;
  localparam byte_t OFS_RXWIN = 8'h05;
  localparam int    CTRL_SEL_BIT = 0;
  localparam int    CTRL_CLR_BIT = 1;
endpackage

// File: rtl/dbb_bank.sv
module dbb_bank #(
  parameter int PTR_W = 10
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PTR_W-1:0] addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       q
);
  localparam int DEPTH = 1 << PTR_W;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    q <= mem[addr];
  end
endmodule

// File: rtl/dbb_host_regs.sv
module dbb_host_regs
  import dbb_pkg::*;
#(
  parameter int PTR_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  byte_t            addr,
  input  byte_t            wdata,
  input  logic             host_sel,
  input  logic             pending,
  input  logic             swap_apply,
  input  byte_t            mem_q,
  output byte_t            rdata,
  output logic             ctrl_wr,
  output logic             mem_we,
  output logic [PTR_W-1:0] ptr
);
  localparam int HI_W  = PTR_W - 8;
  localparam int PAD_W = 8 - HI_W;

  logic we_q, oe_q;
  logic wr_ev, rd_ev;
  logic tx_ev, rx_ev, ptrl_ev, ptrh_ev, clr_ev;
  byte_t rd_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q <= 1'b1;
      oe_q <= 1'b1;
    end else begin
      we_q <= we_n;
      oe_q <= oe_n;
    end
  end

  assign wr_ev   = !cs_n && !we_n && we_q;
  assign rd_ev   = !cs_n && !oe_n && oe_q;
  assign tx_ev   = wr_ev && (addr == OFS_TXWIN);
  assign rx_ev   = rd_ev && (addr == OFS_RXWIN);
  assign ptrl_ev = wr_ev && (addr == OFS_PTRL);
  assign ptrh_ev = wr_ev && (addr == OFS_PTRH);
  assign ctrl_wr = wr_ev && (addr == OFS_CTRL);
  assign clr_ev  = ctrl_wr && wdata[CTRL_CLR_BIT];
  assign mem_we  = tx_ev;

  always_comb begin
    unique case (addr)
      OFS_CTRL:  rd_sel = {6'b0, pending, host_sel};
      OFS_PTRL:  rd_sel = ptr[7:0];
      OFS_PTRH:  rd_sel = {{PAD_W{1'b0}}, ptr[PTR_W-1:8]};
      OFS_RXWIN: rd_sel = mem_q;
      default:   rd_sel = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr   <= '0;
      rdata <= 8'h00;
    end else begin
      if (rd_ev) rdata <= rd_sel;
      if (swap_apply || clr_ev)  ptr <= '0;
      else if (ptrl_ev)          ptr <= {ptr[PTR_W-1:8], wdata};
      else if (ptrh_ev)          ptr <= {wdata[HI_W-1:0], ptr[7:0]};
      else if (tx_ev || rx_ev)   ptr <= ptr + 1'b1;
    end
  end

  assert_host_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ev || rx_ev) && !swap_apply |=> ptr == $past(ptr) + 1'b1);
  assert_ptr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n && !swap_apply |=> ptr == $past(ptr));
endmodule

// File: rtl/dbb_dma_port.sv
module dbb_dma_port #(
  parameter int PTR_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic             rd_en,
  output logic             rd_valid,
  input  logic             rd_ready,
  input  logic             swap_apply,
  output logic             mem_we,
  output logic [PTR_W-1:0] ptr
);
  logic fresh;
  logic wr_fire, rd_fire;

  assign wr_ready = !rd_en;
  assign wr_fire  = wr_valid && wr_ready;
  assign rd_valid = rd_en && fresh;
  assign rd_fire  = rd_valid && rd_ready;
  assign mem_we   = wr_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr   <= '0;
      fresh <= 1'b0;
    end else begin
      fresh <= !(wr_fire || rd_fire || swap_apply);
      if (swap_apply)             ptr <= '0;
      else if (wr_fire || rd_fire) ptr <= ptr + 1'b1;
    end
  end

  assert_rd_fire_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> ptr == $past(ptr) + 1'b1);
  assert_wr_fire_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> ptr == $past(ptr) + 1'b1);
  assert_rd_no_bubble_loss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> !rd_valid);
endmodule

// File: rtl/dual_bank_buffer.sv
module dual_bank_buffer
  import dbb_pkg::*;
#(
  parameter int PTR_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_cs_n,
  input  logic       host_we_n,
  input  logic       host_oe_n,
  input  logic [7:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       host_rdata_oe,
  input  logic       dma_wr_valid,
  input  logic [7:0] dma_wr_data,
  output logic       dma_wr_ready,
  input  logic       dma_rd_en,
  output logic       dma_rd_valid,
  output logic [7:0] dma_rd_data,
  input  logic       dma_rd_ready
);
  localparam int NBANK = 2;

  logic             sel, tgt, nxt_tgt, pending, swap_apply, dma_idle;
  logic             ctrl_wr, host_we, dma_we;
  logic [PTR_W-1:0] host_ptr, dma_ptr;
  byte_t            bank_q [NBANK];
  byte_t            host_q, dma_q;

  assign dma_idle   = !dma_wr_valid && !dma_rd_en;
  assign nxt_tgt    = ctrl_wr ? host_wdata[CTRL_SEL_BIT] : tgt;
  assign swap_apply = dma_idle && (nxt_tgt != sel);
  assign pending    = (tgt != sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel <= 1'b0;
      tgt <= 1'b0;
    end else begin
      tgt <= nxt_tgt;
      if (swap_apply) sel <= nxt_tgt;
    end
  end

  dbb_host_regs #(.PTR_W(PTR_W)) u_host (
    .clk(clk), .rst_n(rst_n), .cs_n(host_cs_n), .we_n(host_we_n), .oe_n(host_oe_n),
    .addr(host_addr), .wdata(host_wdata), .host_sel(sel), .pending(pending),
    .swap_apply(swap_apply), .mem_q(host_q), .rdata(host_rdata), .ctrl_wr(ctrl_wr),
    .mem_we(host_we), .ptr(host_ptr)
  );

  dbb_dma_port #(.PTR_W(PTR_W)) u_dma (
    .clk(clk), .rst_n(rst_n), .wr_valid(dma_wr_valid), .wr_ready(dma_wr_ready),
    .rd_en(dma_rd_en), .rd_valid(dma_rd_valid), .rd_ready(dma_rd_ready),
    .swap_apply(swap_apply), .mem_we(dma_we), .ptr(dma_ptr)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic             own_host;
    logic             b_we;
    logic [PTR_W-1:0] b_addr;
    byte_t            b_wdata;
    assign own_host = (sel == 1'(b));
    assign b_we     = own_host ? host_we    : dma_we;
    assign b_addr   = own_host ? host_ptr   : dma_ptr;
    assign b_wdata  = own_host ? host_wdata : dma_wr_data;
    dbb_bank #(.PTR_W(PTR_W)) u_bank (
      .clk(clk), .we(b_we), .addr(b_addr), .wdata(b_wdata), .q(bank_q[b])
    );
  end

  assign host_q        = bank_q[sel];
  assign dma_q         = bank_q[!sel];
  assign dma_rd_data   = dma_q;
  assign host_rdata_oe = !host_cs_n && !host_oe_n;

  assert_swap_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != $past(sel)) |-> $past(!dma_wr_valid && !dma_rd_en));
  assert_ptrs_zero_after_swap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != $past(sel)) |-> (host_ptr == '0 && dma_ptr == '0));
  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rd_valid && !dma_rd_ready && dma_rd_en |=>
      !dma_rd_en || (dma_rd_valid && $stable(dma_rd_data)));
  assert_no_write_while_reading_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rd_en && dma_wr_valid |=> dma_ptr == $past(dma_ptr) || $past(dma_rd_valid && dma_rd_ready));
endmodule

// File: tb/tb_dual_bank_buffer.sv
module tb_dual_bank_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int PTR_W = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_cs_n = 1'b1, host_we_n = 1'b1, host_oe_n = 1'b1;
  logic [7:0] host_addr = 8'h00, host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       host_rdata_oe;
  logic       dma_wr_valid = 1'b0;
  logic [7:0] dma_wr_data = 8'h00;
  logic       dma_wr_ready;
  logic       dma_rd_en = 1'b0;
  logic       dma_rd_valid;
  logic [7:0] dma_rd_data;
  logic       dma_rd_ready = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_bank_buffer #(.PTR_W(PTR_W)) dut (
    .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_we_n(host_we_n),
    .host_oe_n(host_oe_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rdata_oe(host_rdata_oe),
    .dma_wr_valid(dma_wr_valid), .dma_wr_data(dma_wr_data), .dma_wr_ready(dma_wr_ready),
    .dma_rd_en(dma_rd_en), .dma_rd_valid(dma_rd_valid), .dma_rd_data(dma_rd_data),
    .dma_rd_ready(dma_rd_ready)
  );

  typedef struct packed {
    logic       rd;
    logic [7:0] addr;
    logic [7:0] data;
    logic [7:0] req;
  } vec_t;

  localparam int NVEC = 18;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 8'h04, 8'h11, 8'd2},  // R2 tx write
    '{1'b0, 8'h04, 8'h22, 8'd2},  // R2
    '{1'b0, 8'h04, 8'h33, 8'd2},  // R2
    '{1'b1, 8'h01, 8'h03, 8'd2},  // R2 pointer advanced three times
    '{1'b0, 8'h01, 8'h00, 8'd3},  // R3 load low byte
    '{1'b1, 8'h05, 8'h11, 8'd2},  // R2 rx read
    '{1'b1, 8'h05, 8'h22, 8'd2},  // R2
    '{1'b1, 8'h05, 8'h33, 8'd2},  // R2
    '{1'b0, 8'h02, 8'h01, 8'd3},  // R3 load high bits
    '{1'b1, 8'h02, 8'h01, 8'd3},  // R3
    '{1'b1, 8'h01, 8'h03, 8'd3},  // R3
    '{1'b0, 8'h00, 8'h02, 8'd3},  // R3 clear through control
    '{1'b1, 8'h02, 8'h00, 8'd3},  // R3
    '{1'b0, 8'h05, 8'h99, 8'd9},  // R9 write to rx window ignored
    '{1'b1, 8'h04, 8'h00, 8'd9},  // R9 tx window reads zero
    '{1'b1, 8'h07, 8'h00, 8'd9},  // R9 unmapped reads zero
    '{1'b1, 8'h01, 8'h00, 8'd9},  // R9 pointer untouched
    '{1'b1, 8'h05, 8'h11, 8'd9}   // R9 storage untouched
  };

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    host_cs_n = 1'b0; host_addr = a; host_wdata = d; host_we_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    host_we_n = 1'b1; host_cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic host_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    host_cs_n = 1'b0; host_addr = a; host_oe_n = 1'b0;
    @(negedge clk);
    d = host_rdata;
    @(negedge clk);
    host_oe_n = 1'b1; host_cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic dma_push(input logic [7:0] d);
    @(negedge clk);
    dma_wr_valid = 1'b1; dma_wr_data = d;
    @(negedge clk);
    dma_wr_valid = 1'b0;
  endtask

  task automatic dma_pop(output logic [7:0] d);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (dma_rd_valid) break;
    end
    d = dma_rd_data;
    dma_rd_ready = 1'b1;
    @(negedge clk);
    dma_rd_ready = 1'b0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] d0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(1, host_rdata, 8'h00, "rdata after reset");
    check(1, {7'b0, dma_rd_valid}, 8'h00, "rd_valid after reset");
    check(1, {7'b0, dma_wr_ready}, 8'h01, "wr_ready after reset");
    host_read(8'h00, d);
    check(1, d, 8'h00, "control after reset");
    host_read(8'h01, d);
    check(1, d, 8'h00, "host pointer after reset");

    // Vector table walk (R2 R3 R9)
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i].rd) begin
        host_read(VEC[i].addr, d);
        check(int'(VEC[i].req), d, VEC[i].data, $sformatf("vector %0d", i));
      end else begin
        host_write(VEC[i].addr, VEC[i].data);
      end
    end

    // R10 strobe with chip select high does nothing (host pointer is 1)
    @(negedge clk);
    host_addr = 8'h01; host_wdata = 8'h55; host_we_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    host_we_n = 1'b1;
    @(negedge clk);
    host_read(8'h01, d);
    check(10, d, 8'h01, "pointer after strobe with cs high");

    // R7 DMA write stream into bank 1
    check(7, {7'b0, dma_wr_ready}, 8'h01, "wr_ready with read disabled");
    dma_push(8'hA0);
    dma_push(8'hA1);
    dma_push(8'hA2);
    dma_push(8'hA3);
    // R6 host bank untouched by DMA writes
    host_read(8'h05, d);
    check(6, d, 8'h22, "host bank after DMA writes");

    // R4 immediate swap while idle
    host_write(8'h00, 8'h01);
    host_read(8'h00, d);
    check(4, d, 8'h01, "control after idle swap");
    // R5 host pointer rewound
    host_read(8'h01, d);
    check(5, d, 8'h00, "host pointer after swap");
    // R6 DMA bytes now visible to host
    host_read(8'h05, d);
    check(6, d, 8'hA0, "swapped bank byte 0");
    host_read(8'h05, d);
    check(6, d, 8'hA1, "swapped bank byte 1");

    // R8 DMA read stream over bank 0 from pointer 0 (R5)
    dma_rd_en = 1'b1;
    dma_pop(d);
    check(5, d, 8'h11, "DMA pointer rewound by swap");
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (dma_rd_valid) break;
    end
    d0 = dma_rd_data;
    repeat (3) @(negedge clk);
    check(8, {7'b0, dma_rd_valid}, 8'h01, "valid held without ready");
    check(8, dma_rd_data, d0, "data held without ready");
    dma_pop(d);
    check(8, d, 8'h22, "second read byte");
    dma_pop(d);
    check(8, d, 8'h33, "third read byte");

    // R7 ready low while read enabled
    check(7, {7'b0, dma_wr_ready}, 8'h00, "wr_ready with read enabled");

    // R4 swap held pending while DMA busy
    host_write(8'h00, 8'h00);
    host_read(8'h00, d);
    check(4, d, 8'h03, "control with pending swap");
    @(negedge clk);
    dma_rd_en = 1'b0;
    repeat (2) @(negedge clk);
    host_read(8'h00, d);
    check(4, d, 8'h00, "control after pending swap applied");
    host_read(8'h05, d);
    check(5, d, 8'h11, "host pointer rewound by deferred swap");
    dma_rd_en = 1'b1;
    dma_pop(d);
    check(6, d, 8'hA0, "DMA sees bank 1 again");
    @(negedge clk);
    dma_rd_en = 1'b0;
    @(negedge clk);

    // R3 pointer wrap at the top of the bank
    host_write(8'h01, 8'hFF);
    host_write(8'h02, 8'h03);
    host_write(8'h04, 8'h5A);
    host_read(8'h01, d);
    check(3, d, 8'h00, "pointer low after wrap");
    host_read(8'h02, d);
    check(3, d, 8'h00, "pointer high after wrap");
    host_write(8'h01, 8'hFF);
    host_write(8'h02, 8'h03);
    host_read(8'h05, d);
    check(3, d, 8'h5A, "byte at last address");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule